// File: doc/BRIEF.md
# Character Video Blanking Generator

This block produces the final blanking for a character-cell raster display. It has three parts. The first is a composite blank, built from the horizontal and vertical display-active flags. The second is a delay line that holds that composite back by the pipeline depth of the character fetch. The third is a partial "top shade" flag that hides a programmable number of leading character rows.

The composite blank moves through a shift register that advances once per character time, on the cycles where the load strobe is high. As a result it reaches the output exactly as many character times late as the path from display memory addressing to serial video. That path is two character times at the default setting. The top shade is a set/reset flag. It is raised at the start of vertical display and dropped by the terminal-count pulse of the first-screen-row counter, so it can end on any character row from 0 to 14.

The serial pixel stream passes through a gate. The gate forces the blank level (0) whenever the delayed composite blank is active or the top shade is set.

Top module: `char_blank_gen`

## Requirements
- R1: While reset is active and right after it, `blank_n` is 0 (blanked), `shade` is 0 and `video_out` is 0.
- R2: The composite display-enable fed into the delay line is 1 only when `hact` and `vact` are both 1. A 1 on `blank_n` means the display is unblanked.
- R3: A change of the composite display-enable appears on `blank_n` after exactly `DEPTH` (default 2) clock edges at which `char_load` is 1, and not after fewer.
- R4: On clock edges where `char_load` is 0 the delay line does not advance, and `blank_n` keeps its value.
- R5: A `frame_start` pulse without `row_tc` sets `shade` to 1 at the next clock edge.
- R6: A `row_tc` pulse clears `shade` to 0 at the next clock edge, and `shade` then stays 0 until the next `frame_start`.
- R7: When `frame_start` and `row_tc` are 1 in the same cycle, the clear wins and `shade` is 0 after the edge. This means the shade ends at row 0.
- R8: `video_out` equals `pix_in` when `blank_n` is 1 and `shade` is 0. Otherwise it is 0.
- R9: With neither `frame_start` nor `row_tc` asserted, `shade` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_load | input | 1 | One-cycle strobe once per character time |
| hact | input | 1 | Horizontal display-active flag |
| vact | input | 1 | Vertical display-active flag |
| frame_start | input | 1 | Pulse at the start of vertical display |
| row_tc | input | 1 | Terminal-count pulse from first-screen-row counter |
| pix_in | input | 1 | Serial pixel data from the character shifter |
| blank_n | output | 1 | Delayed composite blank, active low |
| shade | output | 1 | Top partial blank flag, 1 while rows are hidden |
| video_out | output | 1 | Gated serial video |

## Verification
The bench counts load strobes across a display-active edge. A design with one stage too few or too many would move `blank_n` one character early or late. Long gaps between strobes are inserted so that a delay line clocked on every pixel clock would run through its stages too soon. The shade test puts `frame_start` and `row_tc` in the same cycle, where the wrong priority would leave the top row hidden. The gate is driven with each source of blanking on its own, so that a missing term lets pixels leak through.

// File: rtl/cbg_pkg.sv
package cbg_pkg;

    // Pipeline depth from display memory address to serial video, in characters.
    localparam int unsigned FETCH_DEPTH = 2;

    // Top-shade state register contents.
    typedef struct packed {
        logic active;
    } shade_state_t;

    // Next-state rule for the top shade: clear has priority over set.
    function automatic logic shade_next(input logic cur, input logic set_p, input logic clr_p);
        if (clr_p)      return 1'b0;
        else if (set_p) return 1'b1;
        else            return cur;
    endfunction

endpackage

// File: rtl/cbg_delay_line.sv
module cbg_delay_line #(
    parameter int unsigned DEPTH = cbg_pkg::FETCH_DEPTH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    input  logic din,
    output logic dout
);
    localparam int unsigned LAST = DEPTH - 1;

    typedef struct packed {
        logic [DEPTH-1:0] taps;
    } line_t;

    line_t state_d, state_q;
    logic [DEPTH-1:0] shifted;

    // Stage 0 takes the input; each later stage takes its predecessor.
    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_tap
            if (i == 0) begin : g_head
                assign shifted[i] = din;
            end else begin : g_body
                assign shifted[i] = state_q.taps[i-1];
            end
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        if (advance) begin
            state_d.taps = shifted;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;              // every stage starts blanked
        end else begin
            state_q <= state_d;
        end
    end

    assign dout = state_q.taps[LAST];
endmodule

// File: rtl/cbg_shade_flag.sv
module cbg_shade_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_p,
    input  logic clr_p,
    output logic active
);
    import cbg_pkg::*;

    shade_state_t state_d, state_q;

    always_comb begin
        state_d        = state_q;
        state_d.active = shade_next(state_q.active, set_p, clr_p);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign active = state_q.active;
endmodule

// File: rtl/cbg_video_gate.sv
module cbg_video_gate (
    input  logic pix,
    input  logic enable_n_blank,
    input  logic shade_on,
    output logic vid
);
    // Blank level is 0; either blanking source overrides pixel data.
    always_comb begin
        vid = 1'b0;
        if (enable_n_blank && !shade_on) begin
            vid = pix;
        end
    end
endmodule

// File: rtl/char_blank_gen.sv
module char_blank_gen #(
    parameter int unsigned DEPTH = cbg_pkg::FETCH_DEPTH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic char_load,
    input  logic hact,
    input  logic vact,
    input  logic frame_start,
    input  logic row_tc,
    input  logic pix_in,
    output logic blank_n,
    output logic shade,
    output logic video_out
);
    logic comp_en;

    // Display is enabled only inside both active windows.
    assign comp_en = hact & vact;

    cbg_delay_line #(.DEPTH(DEPTH)) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (char_load),
        .din     (comp_en),
        .dout    (blank_n)
    );

    cbg_shade_flag u_shade (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_p  (frame_start),
        .clr_p  (row_tc),
        .active (shade)
    );

    cbg_video_gate u_gate (
        .pix            (pix_in),
        .enable_n_blank (blank_n),
        .shade_on       (shade),
        .vid            (video_out)
    );
endmodule

// File: rtl/cbg_checker.sv
module cbg_checker (
    input logic clk,
    input logic rst_n,
    input logic char_load,
    input logic frame_start,
    input logic row_tc,
    input logic pix_in,
    input logic blank_n,
    input logic shade,
    input logic video_out
);
    // R4: no strobe, no movement of the delayed blank
    a_r4_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
        !char_load |=> $stable(blank_n));

    // R5: frame start alone raises the shade
    a_r5_shade_set: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !row_tc) |=> shade);

    // R6, R7: terminal count always drops the shade
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        row_tc |=> !shade);

    // R9: shade keeps its value without pulses
    a_r9_shade_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !row_tc) |=> $stable(shade));

    // R8: any blanking source yields blank level
    a_r8_blank_level: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank_n || shade) |-> !video_out);

    // R8: unblanked output follows pixel data
    a_r8_pass_pixel: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_n && !shade) |-> (video_out == pix_in));
endmodule

bind char_blank_gen cbg_checker chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .char_load   (char_load),
    .frame_start (frame_start),
    .row_tc      (row_tc),
    .pix_in      (pix_in),
    .blank_n     (blank_n),
    .shade       (shade),
    .video_out   (video_out)
);

// File: tb/char_blank_gen_test.sv
`timescale 1ns/1ps
module char_blank_gen_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic char_load = 1'b0, hact = 1'b0, vact = 1'b0;
    logic frame_start = 1'b0, row_tc = 1'b0, pix_in = 1'b0;
    logic blank_n, shade, video_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;   // 125 MHz

    char_blank_gen uut (
        .clk(clk), .rst_n(rst_n), .char_load(char_load), .hact(hact), .vact(vact),
        .frame_start(frame_start), .row_tc(row_tc), .pix_in(pix_in),
        .blank_n(blank_n), .shade(shade), .video_out(video_out)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Entered and left at a falling edge; one rising edge in between.
    task automatic step(input logic ld);
        char_load = ld;
        @(posedge clk);
        @(negedge clk);
        char_load = 1'b0;
    endtask

    task automatic flush();
        for (int i = 0; i < 2; i++) step(1'b1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 blank_n", blank_n, 1'b0);
        check("R1 shade", shade, 1'b0);
        check("R1 video_out", video_out, 1'b0);
        rst_n = 1'b1;
        step(1'b0);
        check("R1 blank_n after release", blank_n, 1'b0);
    endtask

    task automatic t_delay();
        hact = 1'b1; vact = 1'b1; pix_in = 1'b1;
        step(1'b1);
        check("R3 one strobe not enough", blank_n, 1'b0);
        for (int i = 0; i < 6; i++) step(1'b0);
        check("R4 no advance without load", blank_n, 1'b0);
        step(1'b1);
        check("R3 unblank after two strobes", blank_n, 1'b1);
        hact = 1'b0;
        step(1'b1);
        check("R3 blank edge not after one strobe", blank_n, 1'b1);
        for (int i = 0; i < 5; i++) step(1'b0);
        check("R4 hold high without load", blank_n, 1'b1);
        step(1'b1);
        check("R3 blank after two strobes", blank_n, 1'b0);
    endtask

    task automatic t_composite();
        hact = 1'b1; vact = 1'b0; flush();
        check("R2 hact only", blank_n, 1'b0);
        hact = 1'b0; vact = 1'b1; flush();
        check("R2 vact only", blank_n, 1'b0);
        hact = 1'b1; vact = 1'b1; flush();
        check("R2 both active", blank_n, 1'b1);
    endtask

    task automatic t_shade();
        frame_start = 1'b1; step(1'b0); frame_start = 1'b0;
        check("R5 shade set", shade, 1'b1);
        for (int i = 0; i < 4; i++) step(1'b1);
        check("R9 shade held", shade, 1'b1);
        row_tc = 1'b1; step(1'b0); row_tc = 1'b0;
        check("R6 shade cleared", shade, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b0);
        check("R6 shade stays clear", shade, 1'b0);
        frame_start = 1'b1; row_tc = 1'b1; step(1'b0);
        frame_start = 1'b0; row_tc = 1'b0;
        check("R7 clear wins", shade, 1'b0);
    endtask

    task automatic t_video();
        hact = 1'b1; vact = 1'b1; flush();
        pix_in = 1'b1; step(1'b0);
        check("R8 pass pixel 1", video_out, 1'b1);
        pix_in = 1'b0; step(1'b0);
        check("R8 pass pixel 0", video_out, 1'b0);
        pix_in = 1'b1;
        frame_start = 1'b1; step(1'b0); frame_start = 1'b0;
        check("R8 shade blanks video", video_out, 1'b0);
        row_tc = 1'b1; step(1'b0); row_tc = 1'b0;
        check("R8 video back after shade", video_out, 1'b1);
        vact = 1'b0; flush();
        check("R8 composite blanks video", video_out, 1'b0);
    endtask

    initial begin
        t_reset();
        t_delay();
        t_composite();
        t_shade();
        t_video();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule